// File: doc/BRIEF.md
# Vector Timestamp Synchronization Unit

This unit keeps the vector timestamp of one thread in a multithreaded system. The timestamp holds one saturating counter per thread, and the unit's own counter sits at index `OWN_ID`. The stamp moves forward only at synchronization operations. On a lock release, the own counter goes up by one, and the new stamp is handed out so that it can be stored in the lock object and appended to a synchronization history log. On a lock acquire, the unit takes the stamp saved in the lock, merges it with its own stamp by taking the larger value of each counter, and then advances its own counter.

When an epoch or an instruction block closes, software sends a block-end event. A block-end does not change the stamp. It raises a tag strobe that carries the current stamp, so that the access signatures gathered in that block can be labelled with it. Acquires and releases raise the same tag strobe, with the stamp as it stood before the update.

A separate combinational comparator takes two vector stamps and sorts the pair into one of three classes: the first happened before the second, the second happened before the first, or the two are concurrent. A race checker uses the concurrent class to pick out pairs of epochs that are candidates for a race.

Top module: `vtsSyncUnit`

## Requirements
- R1: After a synchronous reset, every component of `curStamp` is zero and `releaseStrobe` and `tagValid` are low.
- R2: A release with no acquire in the same cycle adds one to the own component (index `OWN_ID`, bits `OWN_ID*W +: W`) in the next cycle. All other components stay as they were.
- R3: One cycle after each release that is taken, `releaseStrobe` is high for exactly that one cycle, and `releaseStamp` equals the updated `curStamp`. In every other cycle `releaseStrobe` is low.
- R4: An acquire sets each component to the larger of its current value and the matching component of `acqStamp`, then adds one to the own component. The result is visible in the next cycle.
- R5: When an acquire and a release arrive in the same cycle, only the acquire is carried out. The release is ignored: no increment for it and no `releaseStrobe`.
- R6: Components saturate at 2^W-1. An increment of a component that is already at its maximum leaves it at the maximum.
- R7: A block-end alone leaves `curStamp` unchanged. It raises `tagValid` in the next cycle.
- R8: One cycle after any acquire, release or block-end, `tagValid` is high and `tagStamp` holds `curStamp` as it stood before that event. With no event, `tagValid` is low.
- R9: With no acquire and no release, `curStamp` holds its value.
- R10: `aBeforeB` is high when every component of `cmpA` is less than or equal to the matching component of `cmpB` and at least one is strictly less. `bBeforeA` is the mirror case.
- R11: `concurrent` is high when neither order holds. This includes equal stamps. Exactly one of the three comparator outputs is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| acqValid | input | 1 | Lock acquire event |
| acqStamp | input | N*W | Stamp saved in the acquired lock |
| relValid | input | 1 | Lock release event |
| blkEnd | input | 1 | Block or epoch end event |
| cmpA | input | N*W | Comparator operand A |
| cmpB | input | N*W | Comparator operand B |
| curStamp | output | N*W | Current vector timestamp |
| releaseStrobe | output | 1 | One-cycle pulse per taken release |
| releaseStamp | output | N*W | Stamp to write to the lock and append to the log |
| tagValid | output | 1 | Epoch tag strobe |
| tagStamp | output | N*W | Stamp before the event, used to label the block's signatures |
| aBeforeB | output | 1 | A happened before B |
| bBeforeA | output | 1 | B happened before A |
| concurrent | output | 1 | A and B are unordered |

## Verification
The assertions check the following on every cycle: the hold while idle, the single-step advance of the own counter on a release, the pairing of a release with its strobe and stamp, the dropping of a release that collides with an acquire, saturation, the contents of the tag, and the rule that the comparator has exactly one output high. Only the bench scenarios can show certain things. These are the full element-wise merge of an acquire against chosen lock stamps, with the own counter behind, equal to or ahead of the lock's own entry. They also include the exact classification of particular stamp pairs, and the reset values. A cycle-level reference model follows a long stream of mixed events, so that saturation is reached by both acquires and releases.

// File: rtl/vtsPkg.sv
package vtsPkg;
  // Control-to-datapath strobes for one cycle
  typedef struct packed {
    logic doAcq;   // merge with lock stamp and advance own component
    logic doRel;   // advance own component and publish stamp
    logic doTag;   // capture pre-update stamp for signature labelling
  } vtsStrobes_t;
endpackage

// File: rtl/vtsCtrl.sv
module vtsCtrl
  import vtsPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        acqValid,
  input  logic        relValid,
  input  logic        blkEnd,
  output vtsStrobes_t strobes,
  output logic        releaseStrobe,
  output logic        tagValid
);
  // Acquire has priority; a colliding release is dropped
  always_comb begin
    strobes.doAcq = acqValid;
    strobes.doRel = relValid & ~acqValid;
    strobes.doTag = acqValid | relValid | blkEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      releaseStrobe <= 1'b0;
      tagValid      <= 1'b0;
    end else begin
      releaseStrobe <= strobes.doRel;
      tagValid      <= strobes.doTag;
    end
  end
endmodule

// File: rtl/vtsDatapath.sv
module vtsDatapath
  import vtsPkg::*;
#(
  parameter int N      = 8,
  parameter int W      = 8,
  parameter int OWN_ID = 0
) (
  input  logic          clk,
  input  logic          rstN,
  input  vtsStrobes_t   strobes,
  input  logic [N*W-1:0] acqStamp,
  output logic [N*W-1:0] curStamp,
  output logic [N*W-1:0] releaseStamp,
  output logic [N*W-1:0] tagStamp
);
  localparam logic [W-1:0] MAXV = '1;

  logic [N*W-1:0] stampReg;
  logic [N*W-1:0] nextStamp;

  for (genvar i = 0; i < N; i++) begin : gComp
    logic [W-1:0] curC;
    logic [W-1:0] lockC;
    logic [W-1:0] mergedC;
    assign curC  = stampReg[i*W +: W];
    assign lockC = acqStamp[i*W +: W];
    always_comb mergedC = (strobes.doAcq && (lockC > curC)) ? lockC : curC;
    if (i == OWN_ID) begin : gOwn
      assign nextStamp[i*W +: W] = (mergedC == MAXV) ? MAXV : mergedC + 1'b1;
    end else begin : gPeer
      assign nextStamp[i*W +: W] = mergedC;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stampReg     <= '0;
      releaseStamp <= '0;
      tagStamp     <= '0;
    end else begin
      if (strobes.doAcq || strobes.doRel) stampReg <= nextStamp;
      if (strobes.doRel) releaseStamp <= nextStamp;
      if (strobes.doTag) tagStamp <= stampReg;
    end
  end

  assign curStamp = stampReg;
endmodule

// File: rtl/vtsCompare.sv
module vtsCompare #(
  parameter int N = 8,
  parameter int W = 8
) (
  input  logic [N*W-1:0] cmpA,
  input  logic [N*W-1:0] cmpB,
  output logic           aBeforeB,
  output logic           bBeforeA,
  output logic           concurrent
);
  logic [N-1:0] aLe, aLt, bLe, bLt;

  for (genvar i = 0; i < N; i++) begin : gLane
    assign aLe[i] = cmpA[i*W +: W] <= cmpB[i*W +: W];
    assign aLt[i] = cmpA[i*W +: W] <  cmpB[i*W +: W];
    assign bLe[i] = cmpB[i*W +: W] <= cmpA[i*W +: W];
    assign bLt[i] = cmpB[i*W +: W] <  cmpA[i*W +: W];
  end

  always_comb begin
    aBeforeB   = (&aLe) & (|aLt);
    bBeforeA   = (&bLe) & (|bLt);
    concurrent = ~aBeforeB & ~bBeforeA;
  end
endmodule

// File: rtl/vtsSyncUnit.sv
module vtsSyncUnit
  import vtsPkg::*;
#(
  parameter int N      = 8,
  parameter int W      = 8,
  parameter int OWN_ID = 0
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           acqValid,
  input  logic [N*W-1:0] acqStamp,
  input  logic           relValid,
  input  logic           blkEnd,
  input  logic [N*W-1:0] cmpA,
  input  logic [N*W-1:0] cmpB,
  output logic [N*W-1:0] curStamp,
  output logic           releaseStrobe,
  output logic [N*W-1:0] releaseStamp,
  output logic           tagValid,
  output logic [N*W-1:0] tagStamp,
  output logic           aBeforeB,
  output logic           bBeforeA,
  output logic           concurrent
);
  vtsStrobes_t strobes;

  vtsCtrl uCtrl (
    .clk(clk), .rstN(rstN),
    .acqValid(acqValid), .relValid(relValid), .blkEnd(blkEnd),
    .strobes(strobes), .releaseStrobe(releaseStrobe), .tagValid(tagValid)
  );

  vtsDatapath #(.N(N), .W(W), .OWN_ID(OWN_ID)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .acqStamp(acqStamp),
    .curStamp(curStamp), .releaseStamp(releaseStamp), .tagStamp(tagStamp)
  );

  vtsCompare #(.N(N), .W(W)) uCmp (
    .cmpA(cmpA), .cmpB(cmpB),
    .aBeforeB(aBeforeB), .bBeforeA(bBeforeA), .concurrent(concurrent)
  );
endmodule

// File: rtl/vtsSyncUnitChk.sv
module vtsSyncUnitChk #(
  parameter int N      = 8,
  parameter int W      = 8,
  parameter int OWN_ID = 0
) (
  input logic           clk,
  input logic           rstN,
  input logic           acqValid,
  input logic           relValid,
  input logic           blkEnd,
  input logic [N*W-1:0] curStamp,
  input logic           releaseStrobe,
  input logic [N*W-1:0] releaseStamp,
  input logic           tagValid,
  input logic [N*W-1:0] tagStamp,
  input logic           aBeforeB,
  input logic           bBeforeA,
  input logic           concurrent
);
  localparam logic [W-1:0] MAXV = '1;
  logic [W-1:0] ownC;
  assign ownC = curStamp[OWN_ID*W +: W];

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!acqValid && !relValid) |=> $stable(curStamp)); // R9

  AST_RELEASE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (relValid && !acqValid && ownC != MAXV) |=> ownC == $past(ownC) + 1'b1); // R2

  AST_RELEASE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (relValid && !acqValid) |=> (releaseStrobe && releaseStamp == curStamp)); // R3

  AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(relValid && !acqValid) |=> !releaseStrobe); // R3

  AST_ACQ_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (acqValid && ownC != MAXV) |=> ownC > $past(ownC)); // R4

  AST_COLLIDE_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (acqValid && relValid) |=> !releaseStrobe); // R5

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((acqValid || relValid) && ownC == MAXV) |=> ownC == MAXV); // R6

  AST_BLOCK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (blkEnd && !acqValid && !relValid) |=> ($stable(curStamp) && tagValid)); // R7

  AST_TAG_STAMP: assert property (@(posedge clk) disable iff (!rstN)
    (acqValid || relValid || blkEnd) |=> (tagValid && tagStamp == $past(curStamp))); // R8

  AST_CMP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({aBeforeB, bBeforeA, concurrent}) == 1); // R11
endmodule

bind vtsSyncUnit vtsSyncUnitChk #(.N(N), .W(W), .OWN_ID(OWN_ID)) uChk (
  .clk(clk), .rstN(rstN), .acqValid(acqValid), .relValid(relValid),
  .blkEnd(blkEnd), .curStamp(curStamp), .releaseStrobe(releaseStrobe),
  .releaseStamp(releaseStamp), .tagValid(tagValid), .tagStamp(tagStamp),
  .aBeforeB(aBeforeB), .bBeforeA(bBeforeA), .concurrent(concurrent)
);

// File: tb/vtsSyncUnit_test.sv
module vtsSyncUnit_test;
  localparam int N = 8;
  localparam int W = 4;
  localparam int OWN = 1;
  localparam int MAXV = (1 << W) - 1;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic acqValid = 1'b0, relValid = 1'b0, blkEnd = 1'b0;
  logic [N*W-1:0] acqStamp = '0, cmpA = '0, cmpB = '0;
  logic [N*W-1:0] curStamp, releaseStamp, tagStamp;
  logic releaseStrobe, tagValid, aBeforeB, bBeforeA, concurrent;

  always #(CLK_PERIOD/2) clk = ~clk;

  vtsSyncUnit #(.N(N), .W(W), .OWN_ID(OWN)) uut (
    .clk(clk), .rstN(rstN), .acqValid(acqValid), .acqStamp(acqStamp),
    .relValid(relValid), .blkEnd(blkEnd), .cmpA(cmpA), .cmpB(cmpB),
    .curStamp(curStamp), .releaseStrobe(releaseStrobe), .releaseStamp(releaseStamp),
    .tagValid(tagValid), .tagStamp(tagStamp), .aBeforeB(aBeforeB),
    .bBeforeA(bBeforeA), .concurrent(concurrent)
  );

  int checks = 0, errors = 0;
  int refCur[N], refRel[N], refTag[N], lockIn[N], opA[N], opB[N];
  bit refRelStrobe = 0, refTagValid = 0, prevBlkOnly = 0;
  string curReq = "R1";

  function automatic logic [N*W-1:0] packStamp(input int v[N]);
    logic [N*W-1:0] r = '0;
    for (int i = 0; i < N; i++) r[i*W +: W] = v[i][W-1:0];
    return r;
  endfunction

  // 0: A before B, 1: B before A, 2: unordered
  function automatic int orderOf(input int a[N], input int b[N]);
    bit allLe = 1, anyLt = 0, allGe = 1, anyGt = 0;
    for (int i = 0; i < N; i++) begin
      if (a[i] > b[i]) allLe = 0;
      if (a[i] < b[i]) anyLt = 1;
      if (a[i] < b[i]) allGe = 0;
      if (a[i] > b[i]) anyGt = 1;
    end
    if (allLe && anyLt) return 0;
    if (allGe && anyGt) return 1;
    return 2;
  endfunction

  task automatic checkVec(input string req, input string what,
                          input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic checkBit(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Compare registered outputs, then drive one cycle of stimulus and advance the model
  task automatic step(input bit a, input bit r, input bit b, input string req);
    int ord;
    @(negedge clk);
    checkVec(curReq, "curStamp", curStamp, packStamp(refCur));
    checkBit("R3", "releaseStrobe", releaseStrobe, refRelStrobe);
    if (refRelStrobe) checkVec("R3", "releaseStamp", releaseStamp, packStamp(refRel));
    checkBit(prevBlkOnly ? "R7" : "R8", "tagValid", tagValid, refTagValid);
    if (refTagValid) checkVec("R8", "tagStamp", tagStamp, packStamp(refTag));
    acqValid = a; relValid = r; blkEnd = b;
    acqStamp = packStamp(lockIn); cmpA = packStamp(opA); cmpB = packStamp(opB);
    #1;
    ord = orderOf(opA, opB);
    checkBit("R10", "aBeforeB", aBeforeB, ord == 0);
    checkBit("R10", "bBeforeA", bBeforeA, ord == 1);
    checkBit("R11", "concurrent", concurrent, ord == 2);
    refTagValid = a || r || b;
    if (refTagValid) refTag = refCur;
    refRelStrobe = r && !a;
    if (a) begin
      for (int i = 0; i < N; i++) if (lockIn[i] > refCur[i]) refCur[i] = lockIn[i];
      if (refCur[OWN] < MAXV) refCur[OWN]++;
    end else if (r) begin
      if (refCur[OWN] < MAXV) refCur[OWN]++;
      refRel = refCur;
    end
    prevBlkOnly = b && !a && !r;
    curReq = req;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      refCur[i] = 0; refRel[i] = 0; refTag[i] = 0; lockIn[i] = 0; opA[i] = 0; opB[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R1 reset state checked on the first step; equal operands are unordered (R11)
    step(0, 0, 0, "R1");
    step(0, 0, 0, "R9");
    // R2 releases
    opA[0] = 1; opB[0] = 2;                 // R10 A before B
    step(0, 1, 0, "R2");
    step(0, 1, 0, "R2");
    opA[3] = 5;                             // R11 mixed
    step(0, 0, 1, "R7");                    // R7 block end only
    opB[0] = 0; opA[3] = 0; opA[0] = 1;     // R10 B before A
    // R4 merge: lock ahead on peers, behind on own
    lockIn[0] = 5; lockIn[2] = 3; lockIn[1] = 0;
    step(1, 0, 0, "R4");
    step(0, 0, 0, "R9");
    // R4 lock ahead on own component
    lockIn[1] = 9; lockIn[4] = 2;
    step(1, 0, 0, "R4");
    // R5 collision
    lockIn[5] = 7;
    step(1, 1, 0, "R5");
    step(0, 0, 0, "R9");
    // R6 saturation through releases
    for (int k = 0; k < MAXV + 3; k++) step(0, 1, 0, "R6");
    step(1, 0, 0, "R6");
    step(0, 0, 0, "R9");
    // mixed stream after a fresh reset
    @(negedge clk) rstN = 1'b0;
    @(negedge clk) rstN = 1'b1;
    for (int i = 0; i < N; i++) refCur[i] = 0;
    refRelStrobe = 0; refTagValid = 0; prevBlkOnly = 0; curReq = "R1";
    acqValid = 0; relValid = 0; blkEnd = 0;
    for (int k = 0; k < 400; k++) begin
      int unsigned sel = $urandom % 8;
      for (int i = 0; i < N; i++) begin
        lockIn[i] = $urandom % (MAXV + 1);
        opA[i] = $urandom % 3;
        opB[i] = (k % 3 == 0) ? opA[i] + ($urandom % 2) : $urandom % 3;
      end
      step(sel == 0, sel inside {1, 2, 3}, sel inside {0, 4}, sel == 0 ? "R4" : "R2");
    end
    step(0, 0, 0, "R9");
    step(0, 0, 0, "R9");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule